// File: doc/BRIEF.md
# Memory Fault Diagnostic Tester

This block is a self-test engine for a small synchronous memory. A single start pulse makes it take over the memory port and run two test stages. The first stage writes a checkerboard value to every word and reads the words back. It then does the same with the bitwise complement of that value. The second stage looks for address lines that cause aliasing. It fills the memory with a background value, plants a marker word at address zero and at each power-of-two address in turn, and probes those same addresses for the marker.

When the run ends, the engine raises `done`. It then reports a classification of what it found. The reported results are the first failing address, the OR of all bit errors seen during the data stage, and the data bits that never changed value. It also reports the data bits that were wrong at every address in one of the two passes, which points to a data-line fault. A separate flag marks an isolated cell fault, and a vector holds one flag per address line that aliases. `pass` is high only for a clean run. All results stay unchanged until the next start.

The memory must return read data on the clock edge that follows a read enable. A write takes effect on the edge at which it is presented.

Top module: `memdiag_top`

## Requirements
- R1: After reset, `done`, `pass`, `firstFailValid` and `cellFault` are low, and `errMask`, `stuckMask`, `lineFaultMask`, `aliasMask` and `firstFailAddr` are zero.
- R2: In the data stage, the engine writes the value PAT (default 8'h55) to every address and then reads every address back. It then repeats the write and the read with ~PAT. A read value is compared in the cycle after `memRe`. `memWe` and `memRe` are never high together, and every written word is PAT or ~PAT.
- R3: `errMask` is the OR of expected XOR read data over every read in the data stage.
- R4: `firstFailValid` goes high if any read in the data stage mismatches. `firstFailAddr` is the address of the earliest such read in time.
- R5: Bit b of `stuckMask` is set when data bit b read the same value on every read in the data stage, across both PAT and ~PAT.
- R6: Bit b of `lineFaultMask` is set when data bit b mismatched at every address within the PAT pass, or at every address within the ~PAT pass.
- R7: `cellFault` is high when `errMask` has a set bit that is not set in `lineFaultMask`.
- R8: The alias stage fills the memory with PAT. It then visits marker positions in turn: address 0, then each address 2^k. At each position it writes ~PAT there and reads the probe set {0, 2^j}, skipping the marker's own address. A probe read is a hit when it differs from PAT in a bit that is clear in `errMask`. A hit sets the `aliasMask` bit of the marker's address line and of the probe's address line; address 0 names no line. The marker is then restored to PAT.
- R9: When `done` is high, `pass` is high exactly when no data-stage mismatch occurred, `stuckMask` is zero and `aliasMask` is zero.
- R10: `start` is accepted whenever the engine is idle. In the cycle after it is accepted, `done` is low and every result is cleared. `done` stays low until the run ends. It then stays high, with every result unchanged and the memory port quiet, until the next accepted start.
- R11: A `start` pulse during a run is ignored. The run ends in the same number of cycles and gives the same results as a run with no extra pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a test run |
| memAddr | output | AW | Memory word address |
| memWdata | output | DW | Memory write data |
| memWe | output | 1 | Memory write enable |
| memRe | output | 1 | Memory read enable |
| memRdata | input | DW | Memory read data, valid one cycle after memRe |
| done | output | 1 | Run finished, results valid |
| pass | output | 1 | Run found no fault |
| firstFailValid | output | 1 | A data-stage mismatch was seen |
| firstFailAddr | output | AW | Address of the earliest mismatch |
| errMask | output | DW | Accumulated per-bit error mask |
| stuckMask | output | DW | Data bits that never changed value |
| lineFaultMask | output | DW | Data bits wrong at every address within one pass |
| cellFault | output | 1 | Error not explained by a data-line fault |
| aliasMask | output | AW | Address lines found aliasing |

## Verification
The assertions take for granted that `start` is a single-cycle pulse. They also assume the attached memory is a registered-read array, so a word read back reflects every write presented on earlier edges. The bench drives the engine only through such a model. It injects faults only in the model's read path and address decode: stuck data bits, an inverted data line, a single flipping cell, and address bits forced to zero. `start` is raised for exactly one cycle, either when the engine is idle or deliberately during a run.

// File: rtl/memdiag_pkg.sv
package memdiag_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DWR,   // data stage write sweep
    ST_DRD,   // data stage read sweep
    ST_BGW,   // background fill for alias stage
    ST_MKW,   // plant marker
    ST_PRB,   // probe power-of-two addresses
    ST_RSW,   // restore marker position
    ST_FIN
  } state_t;

  typedef struct packed {
    logic clear;
    logic wr;
    logic rd;
    logic useCpl;
    logic cmpData;
    logic cmpAlias;
    logic phaseB;
    logic finish;
  } strobe_t;

endpackage

// File: rtl/memdiag_ctrl.sv
module memdiag_ctrl
  import memdiag_pkg::*;
#(
  parameter int AW = 4,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output strobe_t       stb,
  output logic [AW-1:0] addr,
  output logic [IW-1:0] markIdx,
  output logic [IW-1:0] probeIdx
);

  localparam logic [IW-1:0] LAST_IDX = IW'(AW);

  state_t        state;
  logic [AW-1:0] addrCnt;
  logic          phaseB;

  function automatic logic [AW-1:0] idxAddr(input logic [IW-1:0] idx);
    if (idx == '0) return '0;
    return AW'(1) << (idx - 1'b1);
  endfunction

  wire sweepLast = (addrCnt == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      addrCnt  <= '0;
      phaseB   <= 1'b0;
      markIdx  <= '0;
      probeIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state   <= ST_DWR;
          addrCnt <= '0;
          phaseB  <= 1'b0;
        end
        ST_DWR: begin
          addrCnt <= addrCnt + 1'b1;
          if (sweepLast) state <= ST_DRD;
        end
        ST_DRD: begin
          addrCnt <= addrCnt + 1'b1;
          if (sweepLast) begin
            if (!phaseB) begin
              phaseB <= 1'b1;
              state  <= ST_DWR;
            end else begin
              phaseB <= 1'b0;
              state  <= ST_BGW;
            end
          end
        end
        ST_BGW: begin
          addrCnt <= addrCnt + 1'b1;
          if (sweepLast) begin
            markIdx <= '0;
            state   <= ST_MKW;
          end
        end
        ST_MKW: begin
          probeIdx <= '0;
          state    <= ST_PRB;
        end
        ST_PRB: begin
          probeIdx <= probeIdx + 1'b1;
          if (probeIdx == LAST_IDX) state <= ST_RSW;
        end
        ST_RSW: begin
          if (markIdx == LAST_IDX) state <= ST_FIN;
          else begin
            markIdx <= markIdx + 1'b1;
            state   <= ST_MKW;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb  = '0;
    addr = addrCnt;
    unique case (state)
      ST_IDLE: stb.clear = start;
      ST_DWR: begin
        stb.wr     = 1'b1;
        stb.useCpl = phaseB;
      end
      ST_DRD: begin
        stb.rd      = 1'b1;
        stb.cmpData = 1'b1;
        stb.phaseB  = phaseB;
      end
      ST_BGW: stb.wr = 1'b1;
      ST_MKW: begin
        stb.wr     = 1'b1;
        stb.useCpl = 1'b1;
        addr       = idxAddr(markIdx);
      end
      ST_PRB: begin
        stb.rd       = 1'b1;
        stb.cmpAlias = (probeIdx != markIdx);
        addr         = idxAddr(probeIdx);
      end
      ST_RSW: begin
        stb.wr = 1'b1;
        addr   = idxAddr(markIdx);
      end
      ST_FIN:  stb.finish = 1'b1;
      default: stb = '0;
    endcase
  end

endmodule

// File: rtl/memdiag_dp.sv
module memdiag_dp
  import memdiag_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int IW = 3,
  parameter logic [DW-1:0] PAT = {(DW/2){2'b01}}
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic [AW-1:0] addr,
  input  logic [IW-1:0] markIdx,
  input  logic [IW-1:0] probeIdx,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  output logic          memRe,
  output logic          done,
  output logic          pass,
  output logic          firstFailValid,
  output logic [AW-1:0] firstFailAddr,
  output logic [DW-1:0] errMask,
  output logic [DW-1:0] stuckMask,
  output logic [DW-1:0] lineFaultMask,
  output logic          cellFault,
  output logic [AW-1:0] aliasMask
);

  assign memAddr  = addr;
  assign memWdata = stb.useCpl ? ~PAT : PAT;
  assign memWe    = stb.wr;
  assign memRe    = stb.rd;

  // one-cycle read pipeline: context for the word arriving next cycle
  logic          cmpDataQ, cmpAliasQ, phaseBQ;
  logic [AW-1:0] addrQ;
  logic [IW-1:0] markQ, probeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpDataQ  <= 1'b0;
      cmpAliasQ <= 1'b0;
      phaseBQ   <= 1'b0;
      addrQ     <= '0;
      markQ     <= '0;
      probeQ    <= '0;
    end else begin
      cmpDataQ  <= stb.rd & stb.cmpData;
      cmpAliasQ <= stb.rd & stb.cmpAlias;
      phaseBQ   <= stb.phaseB;
      addrQ     <= addr;
      markQ     <= markIdx;
      probeQ    <= probeIdx;
    end
  end

  wire [DW-1:0] expWord = phaseBQ ? ~PAT : PAT;
  wire [DW-1:0] diff    = expWord ^ memRdata;

  // per-bit trackers
  logic [DW-1:0] seen0, seen1, allWrongA, allWrongB;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN || stb.clear) begin
        seen0[b]     <= 1'b0;
        seen1[b]     <= 1'b0;
        allWrongA[b] <= 1'b1;
        allWrongB[b] <= 1'b1;
      end else if (cmpDataQ) begin
        if (memRdata[b]) seen1[b] <= 1'b1;
        else             seen0[b] <= 1'b1;
        if (!diff[b]) begin
          if (phaseBQ) allWrongB[b] <= 1'b0;
          else         allWrongA[b] <= 1'b0;
        end
      end
    end
  end

  logic          failSeen;
  logic [AW-1:0] firstAddrQ;
  logic [DW-1:0] errQ;
  logic [AW-1:0] aliasQ;

  function automatic logic [AW-1:0] lineOf(input logic [IW-1:0] idx);
    if (idx == '0) return '0;
    return AW'(1) << (idx - 1'b1);
  endfunction

  wire aliasHit = |((memRdata ^ PAT) & ~errQ);

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      failSeen   <= 1'b0;
      firstAddrQ <= '0;
      errQ       <= '0;
      aliasQ     <= '0;
    end else begin
      if (cmpDataQ) begin
        errQ <= errQ | diff;
        if (diff != '0 && !failSeen) begin
          failSeen   <= 1'b1;
          firstAddrQ <= addrQ;
        end
      end
      if (cmpAliasQ && aliasHit)
        aliasQ <= aliasQ | lineOf(markQ) | lineOf(probeQ);
    end
  end

  // classification latched when the run ends
  wire [DW-1:0] stuckNow = ~seen0 | ~seen1;
  wire [DW-1:0] lineNow  = allWrongA | allWrongB;

  logic [DW-1:0] stuckQ, lineQ;
  logic          cellQ, passQ, doneQ;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      stuckQ <= '0;
      lineQ  <= '0;
      cellQ  <= 1'b0;
      passQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else if (stb.finish) begin
      stuckQ <= stuckNow;
      lineQ  <= lineNow;
      cellQ  <= |(errQ & ~lineNow);
      passQ  <= !failSeen && (stuckNow == '0) && (aliasQ == '0);
      doneQ  <= 1'b1;
    end
  end

  assign done           = doneQ;
  assign pass           = passQ;
  assign firstFailValid = failSeen;
  assign firstFailAddr  = firstAddrQ;
  assign errMask        = errQ;
  assign stuckMask      = stuckQ;
  assign lineFaultMask  = lineQ;
  assign cellFault      = cellQ;
  assign aliasMask      = aliasQ;

endmodule

// File: rtl/memdiag_top.sv
module memdiag_top
  import memdiag_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] PAT = {(DW/2){2'b01}}
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  output logic          memWe,
  output logic          memRe,
  input  logic [DW-1:0] memRdata,
  output logic          done,
  output logic          pass,
  output logic          firstFailValid,
  output logic [AW-1:0] firstFailAddr,
  output logic [DW-1:0] errMask,
  output logic [DW-1:0] stuckMask,
  output logic [DW-1:0] lineFaultMask,
  output logic          cellFault,
  output logic [AW-1:0] aliasMask
);

  localparam int IW = $clog2(AW + 2);

  strobe_t       stb;
  logic [AW-1:0] addr;
  logic [IW-1:0] markIdx, probeIdx;

  memdiag_ctrl #(.AW(AW), .IW(IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .stb(stb), .addr(addr), .markIdx(markIdx), .probeIdx(probeIdx)
  );

  memdiag_dp #(.AW(AW), .DW(DW), .IW(IW), .PAT(PAT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .addr(addr),
    .markIdx(markIdx), .probeIdx(probeIdx), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .done(done), .pass(pass), .firstFailValid(firstFailValid),
    .firstFailAddr(firstFailAddr), .errMask(errMask), .stuckMask(stuckMask),
    .lineFaultMask(lineFaultMask), .cellFault(cellFault), .aliasMask(aliasMask)
  );

endmodule

// File: rtl/memdiag_chk.sv
module memdiag_chk #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] PAT = {(DW/2){2'b01}}
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          memWe,
  input logic          memRe,
  input logic [DW-1:0] memWdata,
  input logic          done,
  input logic          pass,
  input logic          firstFailValid,
  input logic [AW-1:0] firstFailAddr,
  input logic [DW-1:0] errMask,
  input logic [DW-1:0] stuckMask,
  input logic [DW-1:0] lineFaultMask,
  input logic          cellFault,
  input logic [AW-1:0] aliasMask
);

  assert_port_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe));

  assert_wdata_value_R2: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memWdata == PAT || memWdata == ~PAT));

  assert_first_implies_err_R4: assert property (@(posedge clk) disable iff (!rstN)
    firstFailValid |-> (errMask != '0));

  assert_stuck_subset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stuckMask & ~errMask) == '0);

  assert_line_subset_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lineFaultMask & ~errMask) == '0);

  assert_cell_reason_R7: assert property (@(posedge clk) disable iff (!rstN)
    cellFault |-> ((errMask & ~lineFaultMask) != '0));

  assert_pass_clean_R9: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> (done && !firstFailValid && errMask == '0 &&
              stuckMask == '0 && aliasMask == '0 && !cellFault));

  assert_quiet_when_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!memWe && !memRe));

  assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done &&
      $stable({pass, firstFailValid, firstFailAddr, errMask, stuckMask,
               lineFaultMask, cellFault, aliasMask})));

  assert_clear_on_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (!done && !pass && !firstFailValid &&
                         errMask == '0 && aliasMask == '0));

endmodule

bind memdiag_top memdiag_chk #(.AW(AW), .DW(DW), .PAT(PAT)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .memWe(memWe), .memRe(memRe),
  .memWdata(memWdata), .done(done), .pass(pass),
  .firstFailValid(firstFailValid), .firstFailAddr(firstFailAddr),
  .errMask(errMask), .stuckMask(stuckMask), .lineFaultMask(lineFaultMask),
  .cellFault(cellFault), .aliasMask(aliasMask)
);

// File: tb/memdiag_top_bench.sv
module memdiag_top_bench;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int NW = 1 << AW;
  localparam logic [DW-1:0] PAT = 8'h55;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata;
  logic          memWe, memRe;
  logic [DW-1:0] memRdata;
  logic          done, pass, firstFailValid, cellFault;
  logic [AW-1:0] firstFailAddr, aliasMask;
  logic [DW-1:0] errMask, stuckMask, lineFaultMask;

  always #10 clk = ~clk;

  memdiag_top #(.AW(AW), .DW(DW), .PAT(PAT)) u_memdiag_top (
    .clk(clk), .rstN(rstN), .start(start),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .done(done), .pass(pass),
    .firstFailValid(firstFailValid), .firstFailAddr(firstFailAddr),
    .errMask(errMask), .stuckMask(stuckMask), .lineFaultMask(lineFaultMask),
    .cellFault(cellFault), .aliasMask(aliasMask)
  );

  // faulty memory model
  logic [DW-1:0] fStuck0 = '0, fStuck1 = '0, fInv = '0, fFlip = '0;
  logic [AW-1:0] fIgn = '0, fCellAddr = '0;
  logic          fCellEn = 1'b0;
  logic [DW-1:0] mem [NW];

  function automatic logic [DW-1:0] faultRead(input logic [AW-1:0] a);
    logic [DW-1:0] v;
    v = mem[a & ~fIgn];
    if (fCellEn && a == fCellAddr) v = v ^ fFlip;
    v = v ^ fInv;
    return (v & ~fStuck0) | fStuck1;
  endfunction

  always_ff @(posedge clk) begin
    if (memWe) mem[memAddr & ~fIgn] <= memWdata;
    if (memRe) memRdata <= faultRead(memAddr);
  end

  int bothCnt = 0, badWr = 0;
  always @(posedge clk) if (rstN) begin
    if (memWe && memRe) bothCnt++;
    if (memWe && memWdata != PAT && memWdata != ~PAT) badWr++;
  end

  int nChecks = 0, nFail = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [7:0] s0, s1, inv;
    logic [3:0] ign;
    logic       cellEn;
    logic [3:0] cellAddr;
    logic [7:0] flip;
    logic [7:0] eErr, eStuck, eLine;
    logic [3:0] eAlias;
    logic       eCell, ePass, eFv;
    logic [3:0] eFa;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 8'h00, 4'h0, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h0, 1'b0, 1'b1, 1'b0, 4'h0},
    '{8'h01, 8'h00, 8'h00, 4'h0, 1'b0, 4'h0, 8'h00, 8'h01, 8'h01, 8'h01, 4'h0, 1'b0, 1'b0, 1'b1, 4'h0},
    '{8'h00, 8'h80, 8'h00, 4'h0, 1'b0, 4'h0, 8'h00, 8'h80, 8'h80, 8'h80, 4'h0, 1'b0, 1'b0, 1'b1, 4'h0},
    '{8'h00, 8'h00, 8'h04, 4'h0, 1'b0, 4'h0, 8'h00, 8'h04, 8'h00, 8'h04, 4'h0, 1'b0, 1'b0, 1'b1, 4'h0},
    '{8'h00, 8'h00, 8'h00, 4'h0, 1'b1, 4'h9, 8'h10, 8'h10, 8'h00, 8'h00, 4'h0, 1'b1, 1'b0, 1'b1, 4'h9},
    '{8'h00, 8'h00, 8'h00, 4'h4, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h4, 1'b0, 1'b0, 1'b0, 4'h0},
    '{8'h08, 8'h00, 8'h00, 4'h8, 1'b0, 4'h0, 8'h00, 8'h08, 8'h08, 8'h08, 4'h8, 1'b0, 1'b0, 1'b1, 4'h0},
    '{8'h00, 8'h00, 8'h00, 4'h3, 1'b0, 4'h0, 8'h00, 8'h00, 8'h00, 8'h00, 4'h3, 1'b0, 1'b0, 1'b0, 4'h0}
  };

  // launch a run; optional extra start pulse at cycle midPulse (0 = none)
  task automatic runOne(input int midPulse, output int lat);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R10", "done low after start", done, 1'b0);
    lat = 1;
    while (!done && lat < 2000) begin
      if (midPulse != 0 && lat == midPulse) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    if (!done) chk("R10", "run completes", 1'b0, 1'b1);
  endtask

  task automatic checkResults(input vec_t v, input string tag);
    chk("R3", {tag, " errMask"}, errMask, v.eErr);
    chk("R4", {tag, " firstFailValid"}, firstFailValid, v.eFv);
    chk("R4", {tag, " firstFailAddr"}, firstFailAddr, v.eFa);
    chk("R5", {tag, " stuckMask"}, stuckMask, v.eStuck);
    chk("R6", {tag, " lineFaultMask"}, lineFaultMask, v.eLine);
    chk("R7", {tag, " cellFault"}, cellFault, v.eCell);
    chk("R8", {tag, " aliasMask"}, aliasMask, v.eAlias);
    chk("R9", {tag, " pass"}, pass, v.ePass);
  endtask

  task automatic setFaults(input vec_t v);
    fStuck0 = v.s0; fStuck1 = v.s1; fInv = v.inv; fIgn = v.ign;
    fCellEn = v.cellEn; fCellAddr = v.cellAddr; fFlip = v.flip;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    int lat, baseLat;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "done", done, 1'b0);
    chk("R1", "pass", pass, 1'b0);
    chk("R1", "firstFailValid", firstFailValid, 1'b0);
    chk("R1", "cellFault", cellFault, 1'b0);
    chk("R1", "masks", {errMask, stuckMask, lineFaultMask, aliasMask, firstFailAddr}, '0);
    rstN = 1'b1;
    @(negedge clk);

    baseLat = 0;
    for (int i = 0; i < NV; i++) begin
      setFaults(VECS[i]);
      runOne(0, lat);
      if (i == 0) baseLat = lat;
      checkResults(VECS[i], $sformatf("vec%0d", i));
    end

    // R10: results held while idle after done
    repeat (7) @(negedge clk);
    chk("R10", "done held", done, 1'b1);
    chk("R10", "aliasMask held", aliasMask, VECS[NV-1].eAlias);

    // R10: faulty run, then a clean run clears results on start
    setFaults(VECS[6]);
    runOne(0, lat);
    checkResults(VECS[6], "rerun6");
    setFaults(VECS[0]);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R10", "cleared errMask", errMask, '0);
    chk("R10", "cleared aliasMask", aliasMask, '0);
    chk("R10", "cleared firstFailValid", firstFailValid, 1'b0);
    lat = 1;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    chk("R10", "latency after clear", lat, baseLat);
    checkResults(VECS[0], "afterClear");

    // R11: start pulse in the middle of a run is ignored
    setFaults(VECS[1]);
    runOne(30, lat);
    chk("R11", "latency with mid pulse", lat, baseLat);
    checkResults(VECS[1], "midPulse");

    // R2: port exclusivity and write values over all runs
    chk("R2", "we and re together", bothCnt, 0);
    chk("R2", "unexpected write data", badWr, 0);

    finishRun();
  end

endmodule